// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the eight synchronised input lines of a general-purpose I/O port and turns selected activity on them into interrupt requests. For each line, software picks whether it reacts to a level or to an edge. It then picks which level (high or low) or which edge (rising or falling). An edge-sensitive line can also be set to react to any transition. Every line owns a raw status bit. A per-line enable mask gates the raw bits into a masked status, and the OR of the masked bits drives one registered interrupt output.

Software reaches the block over the port's byte-wide register bus. It writes the configuration registers and reads them back. It reads the raw and the masked status, and it acknowledges edge events by writing ones to a clear register. A level-sensitive line keeps its status set for as long as its qualifying level holds, so software silences it by removing the level or by masking the line.

Top module: `gpio_irq_detect`

## Requirements
- R1: Register offsets on the bus are 0x404 sense, 0x408 any-edge, 0x40C polarity, 0x410 enable, 0x414 raw status (read-only), 0x418 masked status (read-only) and 0x41C clear (write-only). Bit i of every register belongs to pin i. Read data is combinational from the address. The clear register and every unmapped address read 0, and writes to unmapped addresses change nothing.
- R2: A pin with sense bit 1 is level-sensitive. Its raw status bit equals the qualified level one clock later: the pin value if polarity is 1, and its inverse if polarity is 0.
- R3: A pin with sense bit 0 and any-edge bit 0 is edge-sensitive. Polarity 1 selects the rising edge and polarity 0 the falling edge. On the clock edge where the qualifying transition is first sampled, the raw bit sets, and it then stays set.
- R4: On an edge-sensitive pin with any-edge bit 1, both transitions set the raw bit and the polarity bit is ignored. On a level-sensitive pin the any-edge bit has no effect.
- R5: The masked status reads as raw status AND enable. The interrupt output is a register loaded with the OR of the masked bits, so it changes one clock after the masked status does.
- R6: Writing the clear register clears each edge-latched raw bit whose data bit is 1, on that write's clock edge. Data bits of 0 leave their raw bits unchanged.
- R7: Reset zeroes all configuration registers and the raw status and drives the interrupt low. Pin levels present at reset release produce no edge event.
- R8: On a level-sensitive pin, a clear write has no lasting effect while the qualifying level holds. The raw bit reads 1 again after the write.
- R9: When a qualifying edge is sampled on the same clock edge as a clear of that bit, the raw bit ends up set.
- R10: Edges are found by comparing each pin with its value on the previous clock. A steady pin raises no new event, and a one-cycle pulse presents both a rising and a falling transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe, one write per asserted cycle |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| pins_in | input | 8 | Synchronised pin inputs |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
Each pin's history register and its latched status bit are the state that matters. A stale history value shows up as a missing or extra raw status bit, readable on the clock right after the pin moves. A status bit stuck at 1 or 0 reaches the masked status in the same cycle and the interrupt output one clock later. The bench therefore reads status immediately after each stimulus edge and checks the interrupt exactly one cycle behind the masked status. The bus makes every corruption visible within two clocks.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_ADDR_W = 12;

    localparam logic [REG_ADDR_W-1:0] OFS_SENSE  = 12'h404;
    localparam logic [REG_ADDR_W-1:0] OFS_ANYEDG = 12'h408;
    localparam logic [REG_ADDR_W-1:0] OFS_POLAR  = 12'h40C;
    localparam logic [REG_ADDR_W-1:0] OFS_ENABLE = 12'h410;
    localparam logic [REG_ADDR_W-1:0] OFS_RAW    = 12'h414;
    localparam logic [REG_ADDR_W-1:0] OFS_MASKED = 12'h418;
    localparam logic [REG_ADDR_W-1:0] OFS_CLEAR  = 12'h41C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SENSE,
        SEL_ANYEDG,
        SEL_POLAR,
        SEL_ENABLE,
        SEL_RAW,
        SEL_MASKED,
        SEL_CLEAR
    } reg_sel_e;

    // Per-pin detection setup carried into each pin cell.
    typedef struct packed {
        logic level_mode;  // 1: level sensitive, 0: edge sensitive
        logic any_edge;    // edge pins: react to both transitions
        logic active_hi;   // 1: high level / rising edge
    } pin_cfg_t;

    function automatic reg_sel_e decode_ofs(input logic [REG_ADDR_W-1:0] a);
        case (a)
            OFS_SENSE:  return SEL_SENSE;
            OFS_ANYEDG: return SEL_ANYEDG;
            OFS_POLAR:  return SEL_POLAR;
            OFS_ENABLE: return SEL_ENABLE;
            OFS_RAW:    return SEL_RAW;
            OFS_MASKED: return SEL_MASKED;
            OFS_CLEAR:  return SEL_CLEAR;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic edge_qualify(input logic rise, input logic fall,
                                          input pin_cfg_t cfg);
        if (cfg.any_edge)
            return rise | fall;
        return cfg.active_hi ? rise : fall;
    endfunction

    function automatic logic level_qualify(input logic pin, input pin_cfg_t cfg);
        return cfg.active_hi ? pin : ~pin;
    endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [NUM_PINS-1:0]   wdata,
    input  logic [NUM_PINS-1:0]   raw_st,
    input  logic [NUM_PINS-1:0]   masked_st,
    output logic [NUM_PINS-1:0]   sense_q,
    output logic [NUM_PINS-1:0]   anyedg_q,
    output logic [NUM_PINS-1:0]   polar_q,
    output logic [NUM_PINS-1:0]   enable_q,
    output logic [NUM_PINS-1:0]   clr_pulse,
    output logic [NUM_PINS-1:0]   rdata
);

    reg_sel_e sel;

    assign sel = decode_ofs(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q  <= '0;
            anyedg_q <= '0;
            polar_q  <= '0;
            enable_q <= '0;
        end else if (we) begin
            case (sel)
                SEL_SENSE:  sense_q  <= wdata;
                SEL_ANYEDG: anyedg_q <= wdata;
                SEL_POLAR:  polar_q  <= wdata;
                SEL_ENABLE: enable_q <= wdata;
                default: ;
            endcase
        end
    end

    // Clear strobe lasts exactly the cycle of the write.
    always_comb begin
        clr_pulse = '0;
        if (we && sel == SEL_CLEAR)
            clr_pulse = wdata;
    end

    always_comb begin
        case (sel)
            SEL_SENSE:  rdata = sense_q;
            SEL_ANYEDG: rdata = anyedg_q;
            SEL_POLAR:  rdata = polar_q;
            SEL_ENABLE: rdata = enable_q;
            SEL_RAW:    rdata = raw_st;
            SEL_MASKED: rdata = masked_st;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_pin_cell.sv
module gpio_irq_pin_cell
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    input  pin_cfg_t cfg,
    input  logic     clr,
    output logic     prev,
    output logic     raw
);

    logic pin_q;
    logic raw_q;
    logic rise;
    logic fall;
    logic edge_hit;
    logic level_hit;
    logic raw_d;

    assign rise      = pin & ~pin_q;
    assign fall      = ~pin & pin_q;
    assign edge_hit  = edge_qualify(rise, fall, cfg);
    assign level_hit = level_qualify(pin, cfg);

    // Level pins track the level; edge pins latch, a new edge beats a clear.
    always_comb begin
        if (cfg.level_mode)
            raw_d = level_hit;
        else
            raw_d = edge_hit | (raw_q & ~clr);
    end

    // History loads during reset too, so the released state is no edge.
    always_ff @(posedge clk) begin
        pin_q <= pin;
        if (rst)
            raw_q <= 1'b0;
        else
            raw_q <= raw_d;
    end

    assign prev = pin_q;
    assign raw  = raw_q;

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] raw_st,
    input  logic [NUM_PINS-1:0] enable,
    output logic [NUM_PINS-1:0] masked_st,
    output logic                irq
);

    logic irq_q;

    assign masked_st = raw_st & enable;

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |masked_st;
    end

    assign irq = irq_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_we,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [NUM_PINS-1:0]   bus_wdata,
    output logic [NUM_PINS-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0]   pins_in,
    output logic                  irq_out
);

    logic [NUM_PINS-1:0] sense_v;
    logic [NUM_PINS-1:0] anyedg_v;
    logic [NUM_PINS-1:0] polar_v;
    logic [NUM_PINS-1:0] enable_v;
    logic [NUM_PINS-1:0] clr_v;
    logic [NUM_PINS-1:0] raw_v;
    logic [NUM_PINS-1:0] prev_v;
    logic [NUM_PINS-1:0] masked_v;

    gpio_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .raw_st    (raw_v),
        .masked_st (masked_v),
        .sense_q   (sense_v),
        .anyedg_q  (anyedg_v),
        .polar_q   (polar_v),
        .enable_q  (enable_v),
        .clr_pulse (clr_v),
        .rdata     (bus_rdata)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        pin_cfg_t cfg;
        assign cfg.level_mode = sense_v[g];
        assign cfg.any_edge   = anyedg_v[g];
        assign cfg.active_hi  = polar_v[g];

        gpio_irq_pin_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .pin  (pins_in[g]),
            .cfg  (cfg),
            .clr  (clr_v[g]),
            .prev (prev_v[g]),
            .raw  (raw_v[g])
        );
    end

    gpio_irq_combine #(.NUM_PINS(NUM_PINS)) u_comb (
        .clk       (clk),
        .rst       (rst),
        .raw_st    (raw_v),
        .enable    (enable_v),
        .masked_st (masked_v),
        .irq       (irq_out)
    );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] pins,
    input logic [NUM_PINS-1:0] prev,
    input logic [NUM_PINS-1:0] sense,
    input logic [NUM_PINS-1:0] anyedg,
    input logic [NUM_PINS-1:0] polar,
    input logic [NUM_PINS-1:0] enable,
    input logic [NUM_PINS-1:0] clr,
    input logic [NUM_PINS-1:0] raw,
    input logic                irq
);

    // R2: level pins show last cycle's qualified level
    p_level_follow_r2: assert property (@(posedge clk) disable iff (rst)
        ((raw ^ ($past(polar) ~^ $past(pins))) & $past(sense)) == '0);

    // R3: selected rising edge sets the status
    p_rise_sets_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(~sense & ~anyedg & polar & pins & ~prev) & ~raw) == '0);

    // R3: selected falling edge sets the status
    p_fall_sets_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(~sense & ~anyedg & ~polar & ~pins & prev) & ~raw) == '0);

    // R4: any transition on an any-edge pin sets the status
    p_any_edge_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(~sense & anyedg & (pins ^ prev)) & ~raw) == '0);

    // R5: interrupt follows the masked status by one clock
    p_irq_high_r5: assert property (@(posedge clk) disable iff (rst)
        (|(raw & enable)) |=> irq);
    p_irq_low_r5: assert property (@(posedge clk) disable iff (rst)
        !(|(raw & enable)) |=> !irq);

    // R6: clear without a transition empties the edge status bit
    p_clear_edge_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(clr & ~sense & ~(pins ^ prev)) & raw) == '0);

    // R7: first cycle out of reset is quiet
    p_reset_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (enable == '0 && raw == '0 && !irq));

    // R9: a qualifying edge beats a simultaneous clear
    p_edge_beats_clear_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(clr & ~sense & ~anyedg & polar & pins & ~prev) & ~raw) == '0);

    // R10: steady edge pin with no clear holds its status
    p_steady_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(~sense & ~clr & ~(pins ^ prev)) & (raw ^ $past(raw))) == '0);

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .pins   (pins_in),
    .prev   (prev_v),
    .sense  (sense_v),
    .anyedg (anyedg_v),
    .polar  (polar_v),
    .enable (enable_v),
    .clr    (clr_v),
    .raw    (raw_v),
    .irq    (irq_out)
);

// File: tb/test_gpio_irq_detect.sv
`timescale 1ns/1ps
module test_gpio_irq_detect;

    localparam logic [11:0] A_SENSE = 12'h404;
    localparam logic [11:0] A_ANY   = 12'h408;
    localparam logic [11:0] A_POL   = 12'h40C;
    localparam logic [11:0] A_EN    = 12'h410;
    localparam logic [11:0] A_RAW   = 12'h414;
    localparam logic [11:0] A_MSK   = 12'h418;
    localparam logic [11:0] A_CLR   = 12'h41C;
    localparam logic [7:0]  VEC_EN  = 8'h3C;

    typedef struct packed {
        logic [7:0] sense;
        logic [7:0] anyedg;
        logic [7:0] pol;
        logic [7:0] p0;
        logic [7:0] p1;
        logic [7:0] exp_raw;
    } vec_t;

    // sense, any-edge, polarity, pins before, pins after, expected raw
    localparam vec_t VEC [8] = '{
        '{8'h00, 8'h00, 8'hFF, 8'h00, 8'h0F, 8'h0F},  // R3 rising
        '{8'h00, 8'h00, 8'h00, 8'hFF, 8'hF0, 8'h0F},  // R3 falling
        '{8'h00, 8'hFF, 8'hAA, 8'h3C, 8'hC3, 8'hFF},  // R4 any edge
        '{8'hFF, 8'h00, 8'hF0, 8'h00, 8'h5A, 8'h55},  // R2 levels
        '{8'h0F, 8'hF0, 8'h0F, 8'h00, 8'h30, 8'h30},  // R2/R4 mixed
        '{8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00},  // R4 any-edge ignored on level
        '{8'h00, 8'hFF, 8'hFF, 8'hA5, 8'hA5, 8'h00},  // R10 steady
        '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00}   // R3 wrong direction
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pins_in = 8'hFF;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    gpio_irq_detect i_gpio_irq_detect (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pins_in   (pins_in),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        step(4);
        rst = 1'b0;
        step(2);

        // R7: reset state, pins high at release give no event
        rd(A_SENSE, v); check("R7 sense", v, 8'h00);
        rd(A_ANY, v);   check("R7 anyedge", v, 8'h00);
        rd(A_POL, v);   check("R7 polarity", v, 8'h00);
        rd(A_EN, v);    check("R7 enable", v, 8'h00);
        rd(A_RAW, v);   check("R7 raw", v, 8'h00);
        check("R7 irq", {7'd0, irq_out}, 8'h00);

        // R1: readback, clear reads zero, unmapped ignored
        wr(A_SENSE, 8'h5A); rd(A_SENSE, v); check("R1 sense", v, 8'h5A);
        wr(A_ANY, 8'h3C);   rd(A_ANY, v);   check("R1 anyedge", v, 8'h3C);
        wr(A_POL, 8'hC3);   rd(A_POL, v);   check("R1 polarity", v, 8'hC3);
        wr(A_CLR, 8'hFF);   rd(A_CLR, v);   check("R1 clear reads 0", v, 8'h00);
        wr(12'h400, 8'hFF); rd(A_SENSE, v); check("R1 unmapped write", v, 8'h5A);
        rd(12'h400, v);     check("R1 unmapped read", v, 8'h00);

        // Vector table: R2 R3 R4 R5 R10
        for (int i = 0; i < 8; i++) begin
            wr(A_EN, 8'h00);
            wr(A_SENSE, VEC[i].sense);
            wr(A_ANY, VEC[i].anyedg);
            wr(A_POL, VEC[i].pol);
            pins_in = VEC[i].p0;
            step(2);
            wr(A_CLR, 8'hFF);
            pins_in = VEC[i].p1;
            step(1);
            rd(A_RAW, v);
            check($sformatf("R2/R3/R4/R10 vec %0d raw", i), v, VEC[i].exp_raw);
            wr(A_EN, VEC_EN);
            rd(A_MSK, v);
            check($sformatf("R5 vec %0d masked", i), v, VEC[i].exp_raw & VEC_EN);
            step(1);
            check($sformatf("R5 vec %0d irq", i), {7'd0, irq_out},
                  {7'd0, |(VEC[i].exp_raw & VEC_EN)});
        end

        // R6: partial clear
        wr(A_EN, 8'h00);
        wr(A_SENSE, 8'h00);
        wr(A_ANY, 8'h00);
        wr(A_POL, 8'hFF);
        pins_in = 8'h00;
        step(2);
        wr(A_CLR, 8'hFF);
        pins_in = 8'hFF;
        step(1);
        rd(A_RAW, v); check("R3 rising all", v, 8'hFF);
        wr(A_CLR, 8'h0F); rd(A_RAW, v); check("R6 clear ones", v, 8'hF0);
        wr(A_CLR, 8'h00); rd(A_RAW, v); check("R6 zero bits no effect", v, 8'hF0);

        // R8: clear on a held level does not stick
        wr(A_SENSE, 8'h01);
        step(1);
        wr(A_CLR, 8'h01);
        rd(A_RAW, v); check("R8 level after clear", v & 8'h01, 8'h01);
        pins_in = 8'hFE;
        step(1);
        rd(A_RAW, v); check("R2 level removed", v & 8'h01, 8'h00);

        // R9: edge and clear together
        wr(A_SENSE, 8'h00);
        pins_in = 8'h00;
        step(2);
        wr(A_CLR, 8'hFF);
        rd(A_RAW, v); check("R6 all cleared", v, 8'h00);
        pins_in = 8'h01;
        wr(A_CLR, 8'h01);
        rd(A_RAW, v); check("R9 edge wins", v, 8'h01);
        wr(A_CLR, 8'h01);
        rd(A_RAW, v); check("R6 clear without edge", v, 8'h00);

        // R10: one-cycle pulse gives both transitions; steady pins quiet
        wr(A_POL, 8'h0F);
        pins_in = 8'h00;
        step(2);
        wr(A_CLR, 8'hFF);
        pins_in = 8'hFF;
        step(1);
        pins_in = 8'h00;
        step(1);
        rd(A_RAW, v); check("R10 pulse", v, 8'hFF);
        wr(A_CLR, 8'hFF);
        step(2);
        rd(A_RAW, v); check("R10 steady no event", v, 8'h00);

        // R5: interrupt latency and masking
        wr(A_POL, 8'hFF);
        wr(A_EN, 8'h01);
        wr(A_CLR, 8'hFF);
        check("R5 irq idle", {7'd0, irq_out}, 8'h00);
        pins_in = 8'h01;
        step(1);
        rd(A_MSK, v); check("R5 masked now", v, 8'h01);
        check("R5 irq one cycle later", {7'd0, irq_out}, 8'h00);
        step(1);
        check("R5 irq raised", {7'd0, irq_out}, 8'h01);
        wr(A_EN, 8'h00);
        step(1);
        check("R5 irq masked off", {7'd0, irq_out}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule